// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Unit

This block is the 32-bit memory-mapped control window of a multi-channel DMA controller. Every channel owns an 8 KiB slice of the address space. In that slice the block stores the channel's configuration, command, descriptor pointer, interrupt mask and stream-command registers. It assembles a status word from state that the descriptor engine reports, and it keeps raw and masked interrupt bits. It drives one level interrupt line per channel.

The descriptor engines sit beside this block and are not part of it. They receive one-cycle strobes when software writes a command or a stream command, and they report completed transfers back as single-cycle event pulses. The bus side is a single-cycle request. The read data and an error flag are registered, so they appear in the cycle after the request. Only full 32-bit accesses are accepted.

Top module: `dmac_regwin`

## Requirements
- R1: The channel index is address bits [ADDR_W-1:13] and the register offset is bits [12:0]. The offsets are: 0x58 saved data pointer, 0x5C saved buffer pointer, 0x60 group pointer, 0x7C group-down pointer, 0x80 command, 0x84 config, 0x88 status, 0x8C interrupt mask, 0x90 acknowledge, 0x94 raw interrupt, 0x98 masked interrupt, 0x9C stream command.
- R2: Only size code 2'b10 (32-bit word) is legal. A request with any other size raises `bus_err` for the next cycle only. Such a request changes no register, gives a read value of 0 and produces no strobe.
- R3: A request whose channel index is NUM_CH or higher is flagged through `bus_err` in the same way as R2 and has no effect.
- R4: Config keeps bits [1:0] and reads back with all upper bits at 0. `ch_en` is config bit 0 AND that channel's `client_present`. `ch_stop` is config bit 1.
- R5: The four pointer registers hold and read back the full 32-bit value written.
- R6: A status read returns the engine state in bits [2:0], the end-of-list flag in bit 5 and the 8-bit stream-command source in bits [15:8]. All other bits read 0. The engine inputs are sampled in the request cycle.
- R7: A command write stores the full value, which reads back. It pulses `cont_stb` for that channel during the single cycle after the request.
- R8: A stream-command write stores all 32 bits, which read back. It drives only bits [9:0] onto `scmd_code` and pulses `scmd_stb` during the cycle after the request.
- R9: Event pulses set raw interrupt bits. Out-data done sets bit 2, in-data done sets bits 1 and 0, and in end-of-packet sets bit 3. Writes to the raw and masked interrupt offsets are ignored.
- R10: Writing the acknowledge register clears every raw bit written as 1. The acknowledge register always reads 0. A bit that an event sets in the same cycle as its acknowledge stays set.
- R11: The mask keeps bits [3:0]. The masked interrupt register reads raw AND mask. `irq` is high exactly when that value is nonzero.
- R12: After reset, config, command, stream command, mask, raw interrupt and all pointers are 0. `irq`, `ch_en` and the strobes are low.
- R13: An offset not listed in R1 reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address relative to the controller base |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after a legal read |
| bus_err | output | 1 | Illegal access flag, in the cycle after the request |
| client_present | input | NUM_CH | A client is attached to the channel |
| ev_out_done | input | NUM_CH | Out-data descriptor completed, pulse |
| ev_in_done | input | NUM_CH | In-data descriptor completed, pulse |
| ev_in_eop | input | NUM_CH | In end-of-packet seen, pulse |
| eng_state | input | 3*NUM_CH | Engine state code per channel |
| eng_eol | input | NUM_CH | Engine reached end of list |
| eng_src | input | 8*NUM_CH | Stream-command source per channel |
| irq | output | NUM_CH | Level interrupt per channel |
| ch_en | output | NUM_CH | Channel enabled |
| ch_stop | output | NUM_CH | Channel stop request |
| cont_stb | output | NUM_CH | Continue strobe |
| scmd_stb | output | NUM_CH | Stream-command strobe |
| scmd_code | output | 10*NUM_CH | Stream-command code per channel |

## Verification
Read data, `bus_err` and both strobes come from registers. They are due in the cycle after the request and last only that cycle. Raw interrupt, mask and config updates, and therefore `irq`, `ch_en` and `ch_stop`, also show from that next cycle. The bench applies stimulus just after a falling edge and lets one rising edge pass. It then compares every output with its reference model at the following falling edge. It advances the model only at that edge, so each result is checked in exactly the cycle it is due.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int WIN_BITS = 13;
  localparam int INTR_W   = 4;
  localparam int STATE_W  = 3;
  localparam int SRC_W    = 8;
  localparam int CODE_W   = 10;
  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SDATA, SEL_SBUF, SEL_GRP, SEL_GDOWN, SEL_CMD, SEL_CFG,
    SEL_STAT, SEL_MASK, SEL_ACK, SEL_RAW, SEL_MASKED, SEL_SCMD
  } reg_sel_e;

  function automatic reg_sel_e offset_to_sel(input logic [WIN_BITS-1:0] off);
    case (off)
      13'h058: return SEL_SDATA;
      13'h05C: return SEL_SBUF;
      13'h060: return SEL_GRP;
      13'h07C: return SEL_GDOWN;
      13'h080: return SEL_CMD;
      13'h084: return SEL_CFG;
      13'h088: return SEL_STAT;
      13'h08C: return SEL_MASK;
      13'h090: return SEL_ACK;
      13'h094: return SEL_RAW;
      13'h098: return SEL_MASKED;
      13'h09C: return SEL_SCMD;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic logic [INTR_W-1:0] event_bits(input logic out_done,
                                                   input logic in_done,
                                                   input logic in_eop);
    return {in_eop, out_done, in_done, in_done};
  endfunction

  function automatic logic [INTR_W-1:0] raw_next(input logic [INTR_W-1:0] raw,
                                                 input logic [INTR_W-1:0] ack,
                                                 input logic [INTR_W-1:0] set);
    return (raw & ~ack) | set;
  endfunction

  function automatic logic [31:0] pack_status(input logic [STATE_W-1:0] st,
                                              input logic eol,
                                              input logic [SRC_W-1:0] src);
    return {{(32-SRC_W-8){1'b0}}, src, 2'b00, eol, 2'b00, st};
  endfunction
endpackage

// File: rtl/dmac_addr_dec.sv
module dmac_addr_dec
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2,
  parameter int ADDR_W = WIN_BITS + CH_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [CH_W-1:0]   chan,
  output reg_sel_e          sel,
  output logic              bad
);
  logic chan_oob;
  assign chan     = addr[ADDR_W-1:WIN_BITS];
  assign sel      = offset_to_sel(addr[WIN_BITS-1:0]);
  assign chan_oob = !({1'b0, chan} < (CH_W+1)'(NUM_CH));
  assign bad      = (size != SIZE_WORD) || chan_oob;
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  reg_sel_e            sel,
  input  logic [31:0]         wdata,
  input  logic                client_present,
  input  logic                ev_out_done,
  input  logic                ev_in_done,
  input  logic                ev_in_eop,
  input  logic [STATE_W-1:0]  eng_state,
  input  logic                eng_eol,
  input  logic [SRC_W-1:0]    eng_src,
  output logic [31:0]         rd_word,
  output logic                irq,
  output logic                ch_en,
  output logic                ch_stop,
  output logic                cont_stb,
  output logic                scmd_stb,
  output logic [CODE_W-1:0]   scmd_code
);
  logic [1:0]        cfg_q;
  logic [31:0]       cmd_q, scmd_q;
  logic [31:0]       ptr_q [4];
  logic [INTR_W-1:0] mask_q, raw_q;

  // named internal events for the assertions
  logic              wr_cmd, wr_scmd, wr_cfg, wr_mask;
  logic [INTR_W-1:0] ev_set, ack_bits, masked;
  logic [1:0]        ptr_idx;
  logic              wr_ptr;

  assign wr_cmd   = wr && (sel == SEL_CMD);
  assign wr_scmd  = wr && (sel == SEL_SCMD);
  assign wr_cfg   = wr && (sel == SEL_CFG);
  assign wr_mask  = wr && (sel == SEL_MASK);
  assign ack_bits = (wr && (sel == SEL_ACK)) ? wdata[INTR_W-1:0] : '0;
  assign ev_set   = event_bits(ev_out_done, ev_in_done, ev_in_eop);
  assign masked   = raw_q & mask_q;

  always_comb begin
    wr_ptr  = wr;
    ptr_idx = 2'd0;
    case (sel)
      SEL_SDATA: ptr_idx = 2'd0;
      SEL_SBUF:  ptr_idx = 2'd1;
      SEL_GRP:   ptr_idx = 2'd2;
      SEL_GDOWN: ptr_idx = 2'd3;
      default:   wr_ptr  = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      cmd_q    <= '0;
      scmd_q   <= '0;
      mask_q   <= '0;
      raw_q    <= '0;
      cont_stb <= 1'b0;
      scmd_stb <= 1'b0;
      for (int i = 0; i < 4; i++) ptr_q[i] <= '0;
    end else begin
      cont_stb <= wr_cmd;
      scmd_stb <= wr_scmd;
      raw_q    <= raw_next(raw_q, ack_bits, ev_set);
      if (wr_cfg)  cfg_q  <= wdata[1:0];
      if (wr_cmd)  cmd_q  <= wdata;
      if (wr_scmd) scmd_q <= wdata;
      if (wr_mask) mask_q <= wdata[INTR_W-1:0];
      if (wr_ptr)  ptr_q[ptr_idx] <= wdata;
    end
  end

  always_comb begin
    case (sel)
      SEL_SDATA, SEL_SBUF, SEL_GRP, SEL_GDOWN: rd_word = ptr_q[ptr_idx];
      SEL_CMD:    rd_word = cmd_q;
      SEL_CFG:    rd_word = {30'b0, cfg_q};
      SEL_STAT:   rd_word = pack_status(eng_state, eng_eol, eng_src);
      SEL_MASK:   rd_word = {{(32-INTR_W){1'b0}}, mask_q};
      SEL_RAW:    rd_word = {{(32-INTR_W){1'b0}}, raw_q};
      SEL_MASKED: rd_word = {{(32-INTR_W){1'b0}}, masked};
      SEL_SCMD:   rd_word = scmd_q;
      default:    rd_word = '0;
    endcase
  end

  assign irq       = |masked;
  assign ch_en     = cfg_q[0] && client_present;
  assign ch_stop   = cfg_q[1];
  assign scmd_code = scmd_q[CODE_W-1:0];

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_out_done |=> raw_q[2]); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ack_bits) && (ev_set == '0)) |=> ((raw_q & $past(ack_bits)) == '0)); // R10
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R11
  AST_CONT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cont_stb |-> $past(wr_cmd)); // R7
  AST_SCMD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    scmd_stb |-> $past(wr_scmd)); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable(cfg_q)); // R4
endmodule

// File: rtl/dmac_regwin.sv
module dmac_regwin
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int ADDR_W = WIN_BITS + CH_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_req,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [1:0]                bus_size,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      bus_err,
  input  logic [NUM_CH-1:0]         client_present,
  input  logic [NUM_CH-1:0]         ev_out_done,
  input  logic [NUM_CH-1:0]         ev_in_done,
  input  logic [NUM_CH-1:0]         ev_in_eop,
  input  logic [STATE_W*NUM_CH-1:0] eng_state,
  input  logic [NUM_CH-1:0]         eng_eol,
  input  logic [SRC_W*NUM_CH-1:0]   eng_src,
  output logic [NUM_CH-1:0]         irq,
  output logic [NUM_CH-1:0]         ch_en,
  output logic [NUM_CH-1:0]         ch_stop,
  output logic [NUM_CH-1:0]         cont_stb,
  output logic [NUM_CH-1:0]         scmd_stb,
  output logic [CODE_W*NUM_CH-1:0]  scmd_code
);
  logic [CH_W-1:0] chan;
  reg_sel_e        sel;
  logic            bad;
  logic            acc_ok, acc_bad;
  logic [31:0]     rd_words [NUM_CH];
  logic [31:0]     rd_mux;

  dmac_addr_dec #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .size(bus_size), .chan(chan), .sel(sel), .bad(bad)
  );

  assign acc_ok  = bus_req && !bad;
  assign acc_bad = bus_req && bad;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_here;
    assign wr_here = acc_ok && bus_we && (chan == CH_W'(c));
    dmac_chan_regs u_ch (
      .clk(clk), .rst_n(rst_n), .wr(wr_here), .sel(sel), .wdata(bus_wdata),
      .client_present(client_present[c]),
      .ev_out_done(ev_out_done[c]), .ev_in_done(ev_in_done[c]),
      .ev_in_eop(ev_in_eop[c]),
      .eng_state(eng_state[c*STATE_W +: STATE_W]), .eng_eol(eng_eol[c]),
      .eng_src(eng_src[c*SRC_W +: SRC_W]),
      .rd_word(rd_words[c]), .irq(irq[c]), .ch_en(ch_en[c]),
      .ch_stop(ch_stop[c]), .cont_stb(cont_stb[c]), .scmd_stb(scmd_stb[c]),
      .scmd_code(scmd_code[c*CODE_W +: CODE_W])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (chan == CH_W'(c)) rd_mux = rd_words[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err   <= acc_bad;
      bus_rdata <= (acc_ok && !bus_we) ? rd_mux : '0;
    end
  end

  AST_BAD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> ((cont_stb | scmd_stb) == '0)); // R2
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0)); // R3
endmodule

// File: tb/dmac_regwin_bench.sv
module dmac_regwin_bench;
  localparam int NCH = 3;
  localparam int AW  = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0] bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err;
  logic [NCH-1:0] client_present = '0, ev_out_done = '0, ev_in_done = '0, ev_in_eop = '0;
  logic [3*NCH-1:0] eng_state = '0;
  logic [NCH-1:0] eng_eol = '0;
  logic [8*NCH-1:0] eng_src = '0;
  logic [NCH-1:0] irq, ch_en, ch_stop, cont_stb, scmd_stb;
  logic [10*NCH-1:0] scmd_code;

  always #10 clk = ~clk;

  dmac_regwin u_dmac_regwin (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .client_present(client_present),
    .ev_out_done(ev_out_done), .ev_in_done(ev_in_done), .ev_in_eop(ev_in_eop),
    .eng_state(eng_state), .eng_eol(eng_eol), .eng_src(eng_src),
    .irq(irq), .ch_en(ch_en), .ch_stop(ch_stop), .cont_stb(cont_stb),
    .scmd_stb(scmd_stb), .scmd_code(scmd_code)
  );

  int n_checks = 0, n_fail = 0;

  // reference model state
  logic [31:0] m_cfg [NCH], m_cmd [NCH], m_scmd [NCH], m_mask [NCH], m_raw [NCH];
  logic [31:0] m_ptr [NCH][4];
  logic        m_cont [NCH], m_sstb [NCH];
  logic [31:0] exp_rd;
  logic        exp_err;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] model_read(input int c, input int off);
    case (off)
      'h58: return m_ptr[c][0];
      'h5C: return m_ptr[c][1];
      'h60: return m_ptr[c][2];
      'h7C: return m_ptr[c][3];
      'h80: return m_cmd[c];
      'h84: return m_cfg[c];
      'h88: return (32'(eng_src[c*8 +: 8]) << 8) | (32'(eng_eol[c]) << 5)
                   | 32'(eng_state[c*3 +: 3]);
      'h8C: return m_mask[c];
      'h94: return m_raw[c];
      'h98: return m_raw[c] & m_mask[c];
      'h9C: return m_scmd[c];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_cfg[c] = 0; m_cmd[c] = 0; m_scmd[c] = 0; m_mask[c] = 0; m_raw[c] = 0;
      m_cont[c] = 0; m_sstb[c] = 0;
      for (int p = 0; p < 4; p++) m_ptr[c][p] = 0;
    end
    exp_rd = 0; exp_err = 0;
  endtask

  // one clock: predict, let the edge pass, compare at the falling edge
  task automatic tick(input string tag);
    int ch, off;
    bit legal;
    logic [31:0] ack, set;
    ch = int'(bus_addr >> 13);
    off = int'(bus_addr & 15'h1FFF);
    legal = bus_req && (bus_size == 2'd2) && (ch < NCH);
    exp_err = bus_req && !legal;
    exp_rd = (legal && !bus_we) ? model_read(ch, off) : 32'h0;
    for (int c = 0; c < NCH; c++) begin
      ack = 0;
      set = 0;
      if (ev_out_done[c]) set = set | 32'h4;
      if (ev_in_done[c])  set = set | 32'h3;
      if (ev_in_eop[c])   set = set | 32'h8;
      m_cont[c] = 0;
      m_sstb[c] = 0;
      if (legal && bus_we && ch == c) begin
        case (off)
          'h58: m_ptr[c][0] = bus_wdata;
          'h5C: m_ptr[c][1] = bus_wdata;
          'h60: m_ptr[c][2] = bus_wdata;
          'h7C: m_ptr[c][3] = bus_wdata;
          'h80: begin m_cmd[c] = bus_wdata; m_cont[c] = 1; end
          'h84: m_cfg[c] = bus_wdata % 4;
          'h8C: m_mask[c] = bus_wdata % 16;
          'h90: ack = bus_wdata % 16;
          'h9C: begin m_scmd[c] = bus_wdata; m_sstb[c] = 1; end
          default: ;
        endcase
      end
      m_raw[c] = (m_raw[c] & ~ack) | set;
    end
    @(posedge clk);
    @(negedge clk);
    chk(bus_rdata === exp_rd, tag, "read data", bus_rdata, exp_rd);
    chk(bus_err === exp_err, tag, "bus_err", 32'(bus_err), 32'(exp_err));
    for (int c = 0; c < NCH; c++) begin
      chk(irq[c] === ((m_raw[c] & m_mask[c]) != 0), "R11", $sformatf("irq ch%0d", c),
          32'(irq[c]), 32'((m_raw[c] & m_mask[c]) != 0));
      chk(ch_en[c] === (m_cfg[c][0] & client_present[c]), "R4", $sformatf("ch_en ch%0d", c),
          32'(ch_en[c]), 32'(m_cfg[c][0] & client_present[c]));
      chk(ch_stop[c] === m_cfg[c][1], "R4", $sformatf("ch_stop ch%0d", c),
          32'(ch_stop[c]), 32'(m_cfg[c][1]));
      chk(cont_stb[c] === m_cont[c], "R7", $sformatf("cont_stb ch%0d", c),
          32'(cont_stb[c]), 32'(m_cont[c]));
      chk(scmd_stb[c] === m_sstb[c], "R8", $sformatf("scmd_stb ch%0d", c),
          32'(scmd_stb[c]), 32'(m_sstb[c]));
      chk(scmd_code[c*10 +: 10] === m_scmd[c][9:0], "R8", $sformatf("scmd_code ch%0d", c),
          32'(scmd_code[c*10 +: 10]), 32'(m_scmd[c][9:0]));
    end
  endtask

  task automatic access(input int c, input int off, input bit we, input logic [1:0] sz,
                        input logic [31:0] d, input string tag);
    bus_req = 1; bus_we = we; bus_size = sz; bus_wdata = d;
    bus_addr = AW'((c << 13) | off);
    tick(tag);
    bus_req = 0; bus_we = 0; bus_size = 2'd2; bus_wdata = 0; bus_addr = 0;
  endtask

  task automatic wr(input int c, input int off, input logic [31:0] d, input string tag);
    access(c, off, 1, 2'd2, d, tag);
  endtask

  task automatic rd(input int c, input int off, input string tag);
    access(c, off, 0, 2'd2, 32'h0, tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    #(20ns * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: reset state of outputs and registers
    tick("R12");
    rd(0, 'h84, "R12"); rd(0, 'h80, "R12"); rd(1, 'h9C, "R12");
    rd(2, 'h8C, "R12"); rd(2, 'h94, "R12"); rd(1, 'h58, "R12");
    // R4: config bits, client gating
    wr(0, 'h84, 32'hFFFF_FFFF, "R4");
    rd(0, 'h84, "R4");
    client_present = 3'b001; tick("R4");
    client_present = 3'b000; tick("R4");
    client_present = 3'b111; wr(1, 'h84, 32'h1, "R4"); tick("R4");
    // R5: pointers
    wr(1, 'h58, 32'hDEAD_BEEF, "R5"); wr(1, 'h5C, 32'h1234_5678, "R5");
    wr(1, 'h60, 32'hA5A5_0F0F, "R5"); wr(1, 'h7C, 32'h8000_0001, "R5");
    rd(1, 'h58, "R5"); rd(1, 'h5C, "R5"); rd(1, 'h60, "R5"); rd(1, 'h7C, "R5");
    rd(0, 'h58, "R5");
    // R6: status composition
    eng_state = {3'd2, 3'd4, 3'd0}; eng_eol = 3'b010; eng_src = {8'hFF, 8'h01, 8'h00};
    rd(1, 'h88, "R6"); rd(2, 'h88, "R6"); rd(0, 'h88, "R6");
    // R7: command write and continue strobe
    wr(2, 'h80, 32'h0000_0001, "R7"); tick("R7"); rd(2, 'h80, "R7");
    wr(2, 'h80, 32'h2, "R7"); wr(2, 'h80, 32'h3, "R7"); tick("R7");
    // R8: stream command
    wr(0, 'h9C, 32'hFFFF_F3FF, "R8"); tick("R8"); rd(0, 'h9C, "R8");
    // R9: event pulses
    ev_out_done = 3'b001; tick("R9"); ev_out_done = 0; rd(0, 'h94, "R9");
    ev_in_done = 3'b001; tick("R9"); ev_in_done = 0; rd(0, 'h94, "R9");
    ev_in_eop = 3'b100; tick("R9"); ev_in_eop = 0; rd(2, 'h94, "R9");
    wr(0, 'h94, 32'h0, "R9"); wr(0, 'h98, 32'hF, "R9"); rd(0, 'h94, "R9");
    // R11: mask and irq
    wr(0, 'h8C, 32'hFFFF_FFF4, "R11"); rd(0, 'h98, "R11"); rd(0, 'h8C, "R11");
    wr(0, 'h8C, 32'h0, "R11"); tick("R11");
    wr(0, 'h8C, 32'hF, "R11");
    // R10: acknowledge
    wr(0, 'h90, 32'h4, "R10"); rd(0, 'h94, "R10"); rd(0, 'h90, "R10");
    ev_in_eop = 3'b001; wr(0, 'h90, 32'h8, "R10"); ev_in_eop = 0; rd(0, 'h94, "R10");
    wr(0, 'h90, 32'hFFFF_FFFF, "R10"); rd(0, 'h94, "R10");
    // R1: channel selection by address bits above the window
    wr(2, 'h8C, 32'h8, "R1"); rd(2, 'h98, "R1"); rd(0, 'h98, "R1"); rd(1, 'h8C, "R1");
    // R2: sub-word accesses
    access(0, 'h84, 1, 2'd0, 32'h0, "R2"); rd(0, 'h84, "R2");
    access(1, 'h58, 1, 2'd1, 32'h0, "R2"); rd(1, 'h58, "R2");
    access(0, 'h80, 1, 2'd0, 32'h5, "R2");
    access(1, 'h58, 0, 2'd3, 32'h0, "R2");
    // R3: channel index out of range
    access(3, 'h84, 1, 2'd2, 32'h3, "R3"); access(3, 'h84, 0, 2'd2, 32'h0, "R3");
    access(3, 'h9C, 1, 2'd2, 32'h7, "R3");
    // R13: unknown offsets
    wr(1, 'h10, 32'hFFFF_FFFF, "R13"); rd(1, 'h10, "R13"); rd(1, 'h0, "R13");
    rd(1, 'h58, "R13");
    summary();
    $finish;
  end
endmodule